// File: doc/BRIEF.md
# Current-Mode PWM Cycle Generator

This block produces the gate pulse train of a current-mode flyback controller. The analog front end reduces its inputs to digital flags. They are a peak-current trip, a light-load indication, an off request from the feedback path and an enable from the protection sequencer. The block turns these into one gate signal. An internal timebase counts ticks of the system clock. Every cycle starts with a gate rising edge. The pulse ends when the current trip fires, after a blanking window has passed, or when the on-time reaches three quarters of the active period, whichever comes first.

The normal switching period is swept up and down around its nominal value by a triangle dither, which spreads the switching spectrum. When the light-load flag is set at a cycle start, the cycle runs at a much longer green-mode period, and the dither is held. The parameter `FAST_VARIANT` selects between two sets of defaults: a 65 kHz base with a 20 kHz green rate, or a 100 kHz base with a 32 kHz green rate. In both sets the timing is derived for a 100 MHz tick. Every tick count can also be overridden directly.

Top module: `pwm_cycle_gen`

## Requirements
- R1: While `rst` is high, and afterwards until the first cycle start, `gate_o` is low. The dither offset is zero after reset, and its first move is upward.
- R2: Each cycle begins with a rising edge of `gate_o`. In normal mode the number of clock cycles between two consecutive rising edges is `NOM_TICKS` plus the dither offset latched at the first of those edges.
- R3: The dither offset changes by `DITHER_STEP` at every cycle start in normal mode. It reverses direction when it reaches `+DITHER_STEP*DITHER_STEPS` or `-DITHER_STEP*DITHER_STEPS`. It does not change at cycle starts in green mode.
- R4: If `light_load` is high at a cycle start, that cycle lasts exactly `GREEN_TICKS` clock cycles, with no dither.
- R5: With no current trip, `gate_o` stays high for floor(3*P/4) clock cycles, where P is the period of that cycle. It is never high for longer.
- R6: `cs_trip` has no effect during the first `BLANK_TICKS` clock cycles of a pulse. If `cs_trip` is held high throughout, the pulse lasts `BLANK_TICKS+1` cycles.
- R7: If `cs_trip` is high in the clock cycle that is the (k+1)-th cycle of a pulse, with k >= `BLANK_TICKS` and k below the duty limit, the pulse lasts k+1 cycles.
- R8: `fb_off` forces `gate_o` low in the same cycle. No new pulse starts while it is high. After it clears, the gate stays low until the next cycle start.
- R9: When `prot_en` is low, `gate_o` is low in the same cycle and the cycle counter is cleared. At the first clock edge with `prot_en` high, a fresh cycle starts, so `gate_o` is high one clock later.
- R10: A change of `light_load` in mid-cycle alters neither the pulse width nor the period of the current cycle. It takes effect at the next cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick of the timebase per cycle |
| rst | input | 1 | Synchronous active-high reset |
| prot_en | input | 1 | Switching permitted by the protection logic |
| cs_trip | input | 1 | Peak current sense comparator has tripped |
| light_load | input | 1 | Feedback indicates light load; selects the green period |
| fb_off | input | 1 | Feedback requests immediate stop of switching |
| gate_o | output | 1 | Gate drive request |

## Verification
The bench targets four classes of error:
- Trips that land exactly on the last blanked tick and on the first unblanked tick. A design that compares off by one here passes a spike, or ignores a real overcurrent.
- The points where the dither turns at both extremes. A wrong reversal runs the period past its range, or leaves it parked at one end.
- Light-load changes made in mid-pulse. Switching the period early stretches or cuts the pulse, and it breaks the 75% duty cap.
- Off requests and disable pulses. A design that waits for a clock edge leaves the gate high for a tick, and one that restarts too eagerly emits a pulse before the cycle boundary.

Long runs of mixed random stimulus are compared cycle by cycle against a model built from the requirements.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;

    localparam int TICK_W = 16;

    typedef logic [TICK_W-1:0]        tick_t;
    typedef logic signed [TICK_W-1:0] offs_t;

    localparam tick_t ONE_TICK = tick_t'(1);

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_GREEN  = 1'b1
    } rate_mode_e;

    typedef enum logic {
        SWEEP_UP   = 1'b0,
        SWEEP_DOWN = 1'b1
    } sweep_dir_e;

    typedef struct packed {
        tick_t      period;
        tick_t      on_limit;
        rate_mode_e mode;
    } cycle_cfg_t;

    // Rounded number of clock ticks in one period of the given rate.
    function automatic int ticks_for_khz(int clk_mhz, int khz);
        return (clk_mhz * 1000 + khz / 2) / khz;
    endfunction

    function automatic int base_khz(bit fast);
        return fast ? 100 : 65;
    endfunction

    function automatic int green_khz(bit fast);
        return fast ? 32 : 20;
    endfunction

    function automatic int dev_khz(bit fast);
        return fast ? 6 : 4;
    endfunction

    // Step so that STEPS steps cover the distance from nominal to the upper rate.
    function automatic int dither_step(bit fast, int clk_mhz, int steps);
        int span;
        span = ticks_for_khz(clk_mhz, base_khz(fast))
             - ticks_for_khz(clk_mhz, base_khz(fast) + dev_khz(fast));
        return (steps > 0) ? span / steps : 0;
    endfunction

    function automatic int blank_ticks(int clk_mhz, int blank_ns);
        return (blank_ns * clk_mhz + 999) / 1000;
    endfunction

    // Three quarters of a period, rounded down.
    function automatic tick_t on_limit_of(tick_t period);
        return tick_t'((32'(period) * 32'd3) >> 2);
    endfunction

endpackage

// File: rtl/pwm_dither_sweep.sv
module pwm_dither_sweep
    import pwmgen_pkg::*;
#(
    parameter int STEP  = 5,
    parameter int STEPS = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  advance,
    output offs_t offset
);

    localparam int SPAN = STEP * STEPS;

    generate
        if (STEP == 0 || STEPS == 0) begin : g_flat
            assign offset = '0;
        end else begin : g_sweep
            offs_t      offs_q;
            sweep_dir_e dir_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    offs_q <= '0;
                    dir_q  <= SWEEP_UP;
                end else if (advance) begin
                    if (dir_q == SWEEP_UP) begin
                        if (offs_q == offs_t'(SPAN)) begin
                            dir_q  <= SWEEP_DOWN;
                            offs_q <= offs_q - offs_t'(STEP);
                        end else begin
                            offs_q <= offs_q + offs_t'(STEP);
                        end
                    end else begin
                        if (offs_q == -offs_t'(SPAN)) begin
                            dir_q  <= SWEEP_UP;
                            offs_q <= offs_q + offs_t'(STEP);
                        end else begin
                            offs_q <= offs_q - offs_t'(STEP);
                        end
                    end
                end
            end

            assign offset = offs_q;

            AST_DITHER_RANGE: assert property (@(posedge clk) disable iff (rst)
                (offset <= offs_t'(SPAN)) && (offset >= -offs_t'(SPAN))); // R3

            AST_DITHER_STEP: assert property (@(posedge clk) disable iff (rst)
                advance |=> ((offset - $past(offset) == offs_t'(STEP)) ||
                             ($past(offset) - offset == offs_t'(STEP)))); // R3

            AST_DITHER_HOLD: assert property (@(posedge clk) disable iff (rst)
                !advance |=> $stable(offset)); // R3
        end
    endgenerate

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwmgen_pkg::*;
#(
    parameter int NOM_TICKS   = 1538,
    parameter int GREEN_TICKS = 5000,
    parameter int SPAN        = 80
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       prot_en,
    input  logic       light_load,
    input  offs_t      offset,
    output logic       start,
    output logic       dither_adv,
    output tick_t      cnt,
    output cycle_cfg_t cfg
);

    logic       run_q;
    tick_t      cnt_q;
    cycle_cfg_t cfg_q;
    cycle_cfg_t cfg_next;

    // Configuration for the cycle that would begin at this edge.
    always_comb begin
        int p;
        if (light_load) begin
            p = GREEN_TICKS;
            cfg_next.mode = MODE_GREEN;
        end else begin
            p = NOM_TICKS + int'(offset);
            cfg_next.mode = MODE_NORMAL;
        end
        cfg_next.period   = tick_t'(p);
        cfg_next.on_limit = on_limit_of(tick_t'(p));
    end

    assign start      = prot_en && (!run_q || (cnt_q == cfg_q.period - ONE_TICK));
    assign dither_adv = start && !light_load;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            cfg_q <= '{period: tick_t'(NOM_TICKS),
                       on_limit: on_limit_of(tick_t'(NOM_TICKS)),
                       mode: MODE_NORMAL};
        end else if (!prot_en) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            cfg_q <= cfg_next;
        end else begin
            cnt_q <= cnt_q + ONE_TICK;
        end
    end

    assign cnt = cnt_q;
    assign cfg = cfg_q;

    AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (rst)
        run_q |-> ((cfg_q.mode == MODE_GREEN) ? (cfg_q.period == tick_t'(GREEN_TICKS))
                  : ((cfg_q.period >= tick_t'(NOM_TICKS - SPAN)) &&
                     (cfg_q.period <= tick_t'(NOM_TICKS + SPAN))))); // R3

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q < cfg_q.period)); // R2

    AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (run_q && prot_en && !start) |=> $stable(cfg_q)); // R10

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !prot_en |=> (!run_q && (cnt_q == '0))); // R9

endmodule

// File: rtl/pwm_blank_window.sv
module pwm_blank_window #(
    parameter int BLANK_TICKS = 23
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic sense_open
);

    generate
        if (BLANK_TICKS == 0) begin : g_none
            assign sense_open = 1'b1;
        end else begin : g_count
            localparam int BW = $clog2(BLANK_TICKS + 1);
            logic [BW-1:0] bcnt_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    bcnt_q <= '0;
                end else if (start) begin
                    bcnt_q <= '0;
                end else if (!sense_open) begin
                    bcnt_q <= bcnt_q + 1'b1;
                end
            end

            assign sense_open = (bcnt_q == BW'(BLANK_TICKS));

            AST_BLANK_CLOSED_AT_START: assert property (@(posedge clk) disable iff (rst)
                start |=> !sense_open); // R6
        end
    endgenerate

endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl
    import pwmgen_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  prot_en,
    input  logic  start,
    input  logic  fb_off,
    input  logic  cs_trip,
    input  logic  sense_open,
    input  tick_t cnt,
    input  tick_t on_limit,
    output logic  gate_o
);

    logic gate_q;
    logic end_pulse;

    assign end_pulse = (cnt == on_limit - ONE_TICK) || fb_off || (cs_trip && sense_open);

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
        end else if (!prot_en) begin
            gate_q <= 1'b0;
        end else if (start) begin
            gate_q <= !fb_off;
        end else if (gate_q && end_pulse) begin
            gate_q <= 1'b0;
        end
    end

    // Off request and disable act on the output without waiting for an edge.
    assign gate_o = gate_q && !fb_off && prot_en;

    AST_DUTY_CAP: assert property (@(posedge clk) disable iff (rst)
        gate_q |-> (cnt < on_limit)); // R5

    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_q) |-> $past(start)); // R2

    AST_OFF_REQ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        fb_off |=> !gate_q); // R8

    AST_BLANKED_TRIP: assert property (@(posedge clk) disable iff (rst)
        (gate_q && prot_en && !sense_open && !fb_off && !start &&
         (cnt != on_limit - ONE_TICK)) |=> gate_q); // R6

    AST_ENABLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !prot_en |=> !gate_q); // R9

endmodule

// File: rtl/pwm_cycle_gen.sv
module pwm_cycle_gen
    import pwmgen_pkg::*;
#(
    parameter int CLK_MHZ      = 100,
    parameter bit FAST_VARIANT = 1'b0,
    parameter int DITHER_STEPS = 16,
    parameter int NOM_TICKS    = ticks_for_khz(CLK_MHZ, base_khz(FAST_VARIANT)),
    parameter int GREEN_TICKS  = ticks_for_khz(CLK_MHZ, green_khz(FAST_VARIANT)),
    parameter int DITHER_STEP  = dither_step(FAST_VARIANT, CLK_MHZ, DITHER_STEPS),
    parameter int BLANK_TICKS  = blank_ticks(CLK_MHZ, 230)
) (
    input  logic clk,
    input  logic rst,
    input  logic prot_en,
    input  logic cs_trip,
    input  logic light_load,
    input  logic fb_off,
    output logic gate_o
);

    localparam int SPAN = DITHER_STEP * DITHER_STEPS;

    offs_t      offset;
    logic       start;
    logic       dither_adv;
    tick_t      cnt;
    cycle_cfg_t cfg;
    logic       sense_open;

    pwm_dither_sweep #(
        .STEP  (DITHER_STEP),
        .STEPS (DITHER_STEPS)
    ) u_dither (
        .clk     (clk),
        .rst     (rst),
        .advance (dither_adv),
        .offset  (offset)
    );

    pwm_timebase #(
        .NOM_TICKS   (NOM_TICKS),
        .GREEN_TICKS (GREEN_TICKS),
        .SPAN        (SPAN)
    ) u_timebase (
        .clk        (clk),
        .rst        (rst),
        .prot_en    (prot_en),
        .light_load (light_load),
        .offset     (offset),
        .start      (start),
        .dither_adv (dither_adv),
        .cnt        (cnt),
        .cfg        (cfg)
    );

    pwm_blank_window #(
        .BLANK_TICKS (BLANK_TICKS)
    ) u_blank (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .sense_open (sense_open)
    );

    pwm_gate_ctrl u_gate (
        .clk        (clk),
        .rst        (rst),
        .prot_en    (prot_en),
        .start      (start),
        .fb_off     (fb_off),
        .cs_trip    (cs_trip),
        .sense_open (sense_open),
        .cnt        (cnt),
        .on_limit   (cfg.on_limit),
        .gate_o     (gate_o)
    );

    initial begin
        AST_TICK_FIT: assert ((NOM_TICKS + SPAN < (1 << (TICK_W - 1))) &&
                              (GREEN_TICKS < (1 << (TICK_W - 1))) &&
                              (NOM_TICKS > SPAN)); // R2
    end

endmodule

// File: tb/pwm_cycle_gen_tb.sv
`timescale 1ns/1ps
module pwm_cycle_gen_tb;

    localparam int NOM   = 200;
    localparam int GREEN = 500;
    localparam int STEP  = 4;
    localparam int STEPS = 4;
    localparam int BLANK = 10;
    localparam int SPAN  = STEP * STEPS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prot_en = 1'b0;
    logic cs_trip = 1'b0;
    logic light_load = 1'b0;
    logic fb_off = 1'b0;
    logic gate_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_cycle_gen #(
        .NOM_TICKS    (NOM),
        .GREEN_TICKS  (GREEN),
        .DITHER_STEP  (STEP),
        .DITHER_STEPS (STEPS),
        .BLANK_TICKS  (BLANK)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .prot_en    (prot_en),
        .cs_trip    (cs_trip),
        .light_load (light_load),
        .fb_off     (fb_off),
        .gate_o     (gate_o)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    function automatic int lim_of(int p);
        return (p * 3) / 4;
    endfunction

    // Dither offset used at the k-th normal cycle start after reset.
    function automatic int tri_at(int k);
        int d = 0;
        bit up = 1'b1;
        for (int i = 0; i < k; i++) begin
            if (up) begin
                if (d == SPAN) begin up = 1'b0; d -= STEP; end
                else d += STEP;
            end else begin
                if (d == -SPAN) begin up = 1'b1; d += STEP; end
                else d -= STEP;
            end
        end
        return d;
    endfunction

    // Cycle model written from the requirements.
    int m_run, m_cnt, m_per, m_lim, m_gate, m_d, m_up;
    always @(posedge clk) begin
        bit st;
        st = prot_en && (m_run == 0 || m_cnt == m_per - 1);
        if (rst) begin
            m_run <= 0; m_cnt <= 0; m_gate <= 0; m_d <= 0; m_up <= 1;
            m_per <= NOM; m_lim <= lim_of(NOM);
        end else if (!prot_en) begin
            m_run <= 0; m_cnt <= 0; m_gate <= 0;
        end else if (st) begin
            m_run <= 1; m_cnt <= 0; m_gate <= fb_off ? 0 : 1;
            if (light_load) begin
                m_per <= GREEN; m_lim <= lim_of(GREEN);
            end else begin
                m_per <= NOM + m_d; m_lim <= lim_of(NOM + m_d);
                if (m_up != 0) begin
                    if (m_d == SPAN) begin m_up <= 0; m_d <= m_d - STEP; end
                    else m_d <= m_d + STEP;
                end else begin
                    if (m_d == -SPAN) begin m_up <= 1; m_d <= m_d + STEP; end
                    else m_d <= m_d - STEP;
                end
            end
        end else begin
            m_cnt <= m_cnt + 1;
            if (m_gate != 0 && (m_cnt == m_lim - 1 || fb_off || (cs_trip && m_cnt >= BLANK)))
                m_gate <= 0;
        end
    end

    always @(posedge clk) begin
        #3;
        check("R7 cycle model", int'(gate_o), (m_gate != 0 && !fb_off && prot_en) ? 1 : 0);
    end

    // Edge monitor.
    int cyc = 0, rise_cnt = 0, fall_cnt = 0, last_rise = 0, last_period = 0, last_width = 0;
    logic prev_g = 1'b0;
    always @(posedge clk) begin
        #2;
        cyc++;
        if (gate_o && !prev_g) begin
            last_period = cyc - last_rise;
            last_rise = cyc;
            rise_cnt++;
        end
        if (!gate_o && prev_g) begin
            last_width = cyc - last_rise;
            fall_cnt++;
        end
        prev_g = gate_o;
    end

    task automatic wait_rise();
        int c = rise_cnt;
        while (rise_cnt == c) @(negedge clk);
    endtask

    task automatic wait_fall();
        int c = fall_cnt;
        while (fall_cnt == c) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int e;
        int rc;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 gate low in reset", int'(gate_o), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 gate low before first start", int'(gate_o), 0);
        check("R9 gate low while disabled", int'(gate_o), 0);
        prot_en = 1'b1;
        @(negedge clk);
        check("R9 first pulse one clock after enable", int'(gate_o), 1);

        // Normal cycles across both dither extremes.
        for (int k = 0; k < 14; k++) begin
            wait_fall();
            check("R5 width at duty cap", last_width, lim_of(NOM + tri_at(k)));
            wait_rise();
            check("R2 period with dither", last_period, NOM + tri_at(k));
            if (k == 4)  check("R3 upper turn point", last_period, NOM + SPAN);
            if (k == 12) check("R3 lower turn point", last_period, NOM - SPAN);
        end

        // Trip held high from the start of the pulse.
        cs_trip = 1'b1;
        wait_fall();
        check("R6 held trip width", last_width, BLANK + 1);
        wait_rise();
        wait_fall();
        check("R6 held trip width again", last_width, BLANK + 1);
        cs_trip = 1'b0;

        // Short trip inside the blanking window.
        wait_rise();
        repeat (5) @(negedge clk);
        cs_trip = 1'b1;
        @(negedge clk);
        cs_trip = 1'b0;
        e = m_lim;
        wait_fall();
        check("R6 blanked spike ignored", last_width, e);

        // Trip after blanking.
        wait_rise();
        repeat (30) @(negedge clk);
        cs_trip = 1'b1;
        wait_fall();
        check("R7 trip ends pulse", last_width, 31);
        cs_trip = 1'b0;
        wait_rise();
        repeat (BLANK) @(negedge clk);
        cs_trip = 1'b1;
        wait_fall();
        check("R7 trip on first open tick", last_width, BLANK + 1);
        cs_trip = 1'b0;

        // Off request.
        wait_rise();
        repeat (20) @(negedge clk);
        fb_off = 1'b1;
        #1 check("R8 off request drops gate at once", int'(gate_o), 0);
        rc = rise_cnt;
        repeat (NOM + SPAN + 10) @(negedge clk);
        check("R8 no pulse while off requested", rise_cnt, rc);
        fb_off = 1'b0;
        #1 check("R8 gate stays low after release", int'(gate_o), 0);
        wait_rise();
        e = m_lim;
        wait_fall();
        check("R8 resumed pulse width", last_width, e);

        // Mode change in mid-pulse.
        wait_rise();
        e = m_lim;
        rc = m_per;
        repeat (20) @(negedge clk);
        light_load = 1'b1;
        wait_fall();
        check("R10 pulse width unchanged", last_width, e);
        wait_rise();
        check("R10 period unchanged", last_period, rc);
        wait_fall();
        check("R4 green width", last_width, lim_of(GREEN));
        wait_rise();
        check("R4 green period", last_period, GREEN);
        wait_rise();
        check("R4 green period without dither", last_period, GREEN);
        light_load = 1'b0;
        wait_fall();
        check("R10 green cycle kept after release", last_width, lim_of(GREEN));
        wait_rise();
        check("R10 green period kept", last_period, GREEN);

        // Disable pulse.
        wait_rise();
        repeat (20) @(negedge clk);
        prot_en = 1'b0;
        #1 check("R9 disable drops gate at once", int'(gate_o), 0);
        repeat (30) @(negedge clk);
        check("R9 gate held low", int'(gate_o), 0);
        prot_en = 1'b1;
        @(negedge clk);
        check("R9 restart one clock after enable", int'(gate_o), 1);
        e = m_lim;
        wait_fall();
        check("R9 clean first pulse", last_width, e);

        // Mixed random stimulus against the model.
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if ($urandom % 8 == 0) cs_trip = ~cs_trip;
            if ($urandom % 700 == 0) light_load = ~light_load;
            if (fb_off) begin
                if ($urandom % 20 == 0) fb_off = 1'b0;
            end else if ($urandom % 400 == 0) fb_off = 1'b1;
            if (prot_en) begin
                if ($urandom % 2500 == 0) prot_en = 1'b0;
            end else if ($urandom % 30 == 0) prot_en = 1'b1;
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule